// File: doc/BRIEF.md
# NAND page layout reorder unit

This block turns the byte stream of one NAND page, arriving in the order the flash controller lays it out, into the buffer layout that software expects. In that buffer every data byte comes first, then every free spare byte, then every ECC byte. Two on-flash layouts are handled. In the Hamming layout the page holds 1, 2 or 4 data chunks of 512 bytes back to back, followed by one 6-byte ECC digest per chunk, followed by the free spare bytes. In the BCH layout each chunk is a self-contained section of data, free spare and a 30-byte ECC field. An optional tail section with its own sizes can close the page. In the user buffer each BCH ECC field takes a 32-byte slot, and the two missing bytes are filled with 0xFF.

A start pulse latches the layout description: mode, chunk count, section sizes and tail sizes. Page bytes then enter on a valid/ready stream. A byte is taken only in a cycle where `in_valid` and `in_ready` are both high, and it is written to the page buffer in that same cycle through `wr_en`/`wr_addr`/`wr_data`. The source may drop `in_valid` at any time without losing data. The unit lowers `in_ready` while it writes pad bytes, because pad bytes use no input. A single-cycle `done` marks the end of the page. The unit does not compute or check ECC.

Top module: `nand_page_reorder`

## Requirements
- R1: While reset is held and after it is released, `wr_en`, `in_ready` and `done` are low until a start is accepted.
- R2: The configuration inputs are sampled only in the cycle a start is accepted. Changing them during a page has no effect on the addresses or data written.
- R3: Hamming mode (`cfg_bch`=0): the first chunks×512 stream bytes are data and are written to addresses 0 up to chunks×512−1, in arrival order.
- R4: Hamming mode: the next chunks×6 bytes are ECC, written from address chunks×512+spare_len upward. The final spare_len bytes are free spare, written from address chunks×512 upward.
- R5: BCH mode (`cfg_bch`=1): section i of chunks carries data_len data bytes, then spare_len spare bytes, then 30 ECC bytes. These go to data address i×data_len, to spare address D+i×spare_len, and to ECC address D+S+32×i. D is the total data length and S is the total spare length, both including the tail.
- R6: After each full BCH ECC field, the bytes at slot offsets 30 and 31 are written as 0xFF. During these writes `in_ready` is low and no input is consumed.
- R7: With `cfg_tail_en`=1 in BCH mode, a tail section follows with tail_data_len, tail_spare_len and tail_ecc_len (0 to 30) bytes. These are placed after the regular sections of each region. If tail_ecc_len is nonzero, its ECC slot is padded with 0xFF up to 32 bytes. If it is zero, no ECC slot is written.
- R8: A byte is consumed, and written, only in a cycle with `in_valid` and `in_ready` both high. Exactly the page's byte count is consumed, and nothing is written while `in_valid` is low except pad bytes.
- R9: `done` is high for exactly one cycle, after the last write of the page. After it, `in_ready` stays low until the next accepted start.
- R10: A start is ignored when a page is in progress, when the chunk count is 0, or when the Hamming chunk count is not 1, 2 or 4. An ignored start causes no write, no `in_ready` and no `done`.
- R11: A zero-length field (a spare length of 0, for instance) produces no write, and the page still completes with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, latches the configuration |
| cfg_bch | input | 1 | 0 = Hamming layout, 1 = BCH layout |
| cfg_chunks | input | CHUNK_W | Number of full chunks/sections |
| cfg_data_len | input | CNT_W | BCH data bytes per section (512..2048) |
| cfg_spare_len | input | CNT_W | Spare bytes per BCH section, or total spare in Hamming mode |
| cfg_tail_en | input | 1 | BCH tail section present |
| cfg_tail_data_len | input | CNT_W | Tail data bytes |
| cfg_tail_spare_len | input | CNT_W | Tail spare bytes |
| cfg_tail_ecc_len | input | ECCL_W | Tail ECC bytes (0..30) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Unit accepts a byte this cycle |
| wr_en | output | 1 | Page-buffer write strobe |
| wr_addr | output | ADDR_W | Page-buffer byte address |
| wr_data | output | 8 | Page-buffer write data |
| done | output | 1 | One-cycle end-of-page pulse |

## Verification
Pages are run in both layouts with continuous input and with pseudo-random gaps in `in_valid`. Continuous input shows that field boundaries cost no lost byte. Gapped input shows that pad writes do not depend on input and that stalls never produce spurious writes. BCH pages with and without a tail, and with a zero-length tail ECC field, separate the regular slot arithmetic from the tail handling. A Hamming page with no spare bytes and ignored starts (chunk count 3, chunk count 0) exercise the skip and rejection paths. One BCH page has its configuration inputs changed right after the start, which shows whether the latched copy is the one in use.

// File: rtl/nrd_pkg.sv
package nrd_pkg;
  typedef enum logic [2:0] {
    K_IDLE,
    K_INIT,
    K_DATA,
    K_SPARE,
    K_ECC,
    K_PAD
  } kind_e;
endpackage

// File: rtl/nrd_cfg.sv
module nrd_cfg #(
  parameter int CHUNK_W  = 4,
  parameter int CNT_W    = 12,
  parameter int ECCL_W   = 5,
  parameter int ADDR_W   = 16,
  parameter int HAM_DATA = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              idle,
  input  logic              i_bch,
  input  logic [CHUNK_W-1:0] i_chunks,
  input  logic [CNT_W-1:0]  i_dlen,
  input  logic [CNT_W-1:0]  i_slen,
  input  logic              i_tail,
  input  logic [CNT_W-1:0]  i_tdlen,
  input  logic [CNT_W-1:0]  i_tslen,
  input  logic [ECCL_W-1:0] i_telen,
  output logic              accept,
  output logic              q_bch,
  output logic [CHUNK_W-1:0] q_chunks,
  output logic [CNT_W-1:0]  q_dlen,
  output logic [CNT_W-1:0]  q_slen,
  output logic              q_tail,
  output logic [CNT_W-1:0]  q_tdlen,
  output logic [CNT_W-1:0]  q_tslen,
  output logic [ECCL_W-1:0] q_telen,
  output logic [ADDR_W-1:0] spare_base,
  output logic [ADDR_W-1:0] ecc_base
);
  logic chunks_ok;
  logic [ADDR_W-1:0] dtot, stot;

  always_comb begin
    if (i_bch) chunks_ok = (i_chunks != '0);
    else chunks_ok = (i_chunks == CHUNK_W'(1)) || (i_chunks == CHUNK_W'(2)) ||
                     (i_chunks == CHUNK_W'(4));
  end

  assign accept = start && idle && chunks_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_bch    <= 1'b0;
      q_chunks <= '0;
      q_dlen   <= '0;
      q_slen   <= '0;
      q_tail   <= 1'b0;
      q_tdlen  <= '0;
      q_tslen  <= '0;
      q_telen  <= '0;
    end else if (accept) begin
      q_bch    <= i_bch;
      q_chunks <= i_chunks;
      q_dlen   <= i_dlen;
      q_slen   <= i_slen;
      q_tail   <= i_bch && i_tail;
      q_tdlen  <= i_tdlen;
      q_tslen  <= i_tslen;
      q_telen  <= i_telen;
    end
  end

  // Region bases follow from the latched sizes
  always_comb begin
    if (q_bch) begin
      dtot = ADDR_W'(q_chunks) * ADDR_W'(q_dlen) + (q_tail ? ADDR_W'(q_tdlen) : '0);
      stot = ADDR_W'(q_chunks) * ADDR_W'(q_slen) + (q_tail ? ADDR_W'(q_tslen) : '0);
    end else begin
      dtot = ADDR_W'(q_chunks) * ADDR_W'(HAM_DATA);
      stot = ADDR_W'(q_slen);
    end
  end

  assign spare_base = dtot;
  assign ecc_base   = dtot + stot;

  // R2: latched layout does not move while a page is in flight
  assert_cfg_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |->
      $stable({q_bch, q_chunks, q_dlen, q_slen, q_tail, q_tdlen, q_tslen, q_telen}));
endmodule

// File: rtl/nrd_seq.sv
module nrd_seq
  import nrd_pkg::*;
#(
  parameter int CHUNK_W  = 4,
  parameter int CNT_W    = 12,
  parameter int ECCL_W   = 5,
  parameter int HAM_DATA = 512,
  parameter int HAM_ECC  = 6,
  parameter int BCH_ECC  = 30,
  parameter int BCH_SLOT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              in_valid,
  input  logic              bch,
  input  logic [CHUNK_W-1:0] chunks,
  input  logic [CNT_W-1:0]  dlen,
  input  logic [CNT_W-1:0]  slen,
  input  logic              tail_en,
  input  logic [CNT_W-1:0]  tdlen,
  input  logic [CNT_W-1:0]  tslen,
  input  logic [ECCL_W-1:0] telen,
  output kind_e             kind,
  output logic              idle,
  output logic              in_ready,
  output logic              pad_wr,
  output logic              beat,
  output logic              done
);
  logic [CNT_W-1:0]   rem, nlen;
  logic [CHUNK_W-1:0] sec, nsec;
  logic               tail, ntail, fin, fld_end;
  kind_e              nk;

  assign idle     = (kind == K_IDLE);
  assign in_ready = (kind inside {K_DATA, K_SPARE, K_ECC}) && (rem != '0);
  assign pad_wr   = (kind == K_PAD) && (rem != '0);
  assign beat     = (in_valid && in_ready) || pad_wr;
  assign fld_end  = !idle && ((rem == '0) || (beat && rem == CNT_W'(1)));

  // Field order per layout
  always_comb begin
    nk    = K_IDLE;
    fin   = 1'b0;
    nsec  = sec;
    ntail = tail;
    unique case (kind)
      K_INIT:  begin nk = K_DATA; nsec = '0; ntail = 1'b0; end
      K_DATA:  nk = bch ? K_SPARE : K_ECC;
      K_ECC:   nk = bch ? K_PAD : K_SPARE;
      K_SPARE: begin
        if (bch) nk = K_ECC;
        else fin = 1'b1;
      end
      K_PAD: begin
        if (!tail && ({1'b0, sec} + 1'b1) < {1'b0, chunks}) begin
          nk = K_DATA; nsec = sec + 1'b1;
        end else if (!tail && tail_en) begin
          nk = K_DATA; ntail = 1'b1;
        end else fin = 1'b1;
      end
      default: fin = 1'b1;
    endcase
  end

  // Length of the field about to start
  always_comb begin
    nlen = '0;
    unique case (nk)
      K_DATA:  nlen = bch ? (ntail ? tdlen : dlen) : CNT_W'(chunks) * CNT_W'(HAM_DATA);
      K_SPARE: nlen = (bch && ntail) ? tslen : slen;
      K_ECC:   nlen = bch ? (ntail ? CNT_W'(telen) : CNT_W'(BCH_ECC))
                          : CNT_W'(chunks) * CNT_W'(HAM_ECC);
      K_PAD:   nlen = ntail ? ((telen != '0) ? CNT_W'(BCH_SLOT) - CNT_W'(telen) : '0)
                            : CNT_W'(BCH_SLOT - BCH_ECC);
      default: nlen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= K_IDLE;
      rem  <= '0;
      sec  <= '0;
      tail <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        kind <= K_INIT;
        rem  <= '0;
        sec  <= '0;
        tail <= 1'b0;
      end else if (fld_end) begin
        if (fin) begin
          kind <= K_IDLE;
          done <= 1'b1;
        end else begin
          kind <= nk;
          rem  <= nlen;
          sec  <= nsec;
          tail <= ntail;
        end
      end else if (beat) begin
        rem <= rem - 1'b1;
      end
    end
  end

  // R9: end-of-page marker lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: without an accepted start the unit stays idle
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !accept) |=> idle);
endmodule

// File: rtl/nrd_addr.sv
module nrd_addr
  import nrd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  kind_e             kind,
  input  logic              beat,
  input  logic [ADDR_W-1:0] spare_base,
  input  logic [ADDR_W-1:0] ecc_base,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [ADDR_W-1:0] dptr, sptr, eptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dptr <= '0;
      sptr <= '0;
      eptr <= '0;
    end else if (kind == K_INIT) begin
      dptr <= '0;
      sptr <= spare_base;
      eptr <= ecc_base;
    end else if (beat) begin
      unique case (kind)
        K_DATA:  dptr <= dptr + 1'b1;
        K_SPARE: sptr <= sptr + 1'b1;
        default: eptr <= eptr + 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      K_DATA:  wr_addr = dptr;
      K_SPARE: wr_addr = sptr;
      default: wr_addr = eptr;
    endcase
  end

  // R3: data writes never spill into the spare region
  assert_data_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_DATA && beat) |-> (wr_addr < spare_base));
endmodule

// File: rtl/nand_page_reorder.sv
module nand_page_reorder
  import nrd_pkg::*;
#(
  parameter int CHUNK_W  = 4,
  parameter int CNT_W    = 12,
  parameter int ECCL_W   = 5,
  parameter int ADDR_W   = 16,
  parameter int HAM_DATA = 512,
  parameter int HAM_ECC  = 6,
  parameter int BCH_ECC  = 30,
  parameter int BCH_SLOT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_bch,
  input  logic [CHUNK_W-1:0] cfg_chunks,
  input  logic [CNT_W-1:0]   cfg_data_len,
  input  logic [CNT_W-1:0]   cfg_spare_len,
  input  logic               cfg_tail_en,
  input  logic [CNT_W-1:0]   cfg_tail_data_len,
  input  logic [CNT_W-1:0]   cfg_tail_spare_len,
  input  logic [ECCL_W-1:0]  cfg_tail_ecc_len,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [7:0]         wr_data,
  output logic               done
);
  localparam logic [7:0] PAD_BYTE = 8'hFF;

  logic               accept, idle, pad_wr, beat;
  logic               q_bch, q_tail;
  logic [CHUNK_W-1:0] q_chunks;
  logic [CNT_W-1:0]   q_dlen, q_slen, q_tdlen, q_tslen;
  logic [ECCL_W-1:0]  q_telen;
  logic [ADDR_W-1:0]  spare_base, ecc_base;
  kind_e              kind;

  nrd_cfg #(
    .CHUNK_W(CHUNK_W), .CNT_W(CNT_W), .ECCL_W(ECCL_W),
    .ADDR_W(ADDR_W), .HAM_DATA(HAM_DATA)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
    .i_bch(cfg_bch), .i_chunks(cfg_chunks), .i_dlen(cfg_data_len),
    .i_slen(cfg_spare_len), .i_tail(cfg_tail_en), .i_tdlen(cfg_tail_data_len),
    .i_tslen(cfg_tail_spare_len), .i_telen(cfg_tail_ecc_len),
    .accept(accept), .q_bch(q_bch), .q_chunks(q_chunks), .q_dlen(q_dlen),
    .q_slen(q_slen), .q_tail(q_tail), .q_tdlen(q_tdlen), .q_tslen(q_tslen),
    .q_telen(q_telen), .spare_base(spare_base), .ecc_base(ecc_base)
  );

  nrd_seq #(
    .CHUNK_W(CHUNK_W), .CNT_W(CNT_W), .ECCL_W(ECCL_W), .HAM_DATA(HAM_DATA),
    .HAM_ECC(HAM_ECC), .BCH_ECC(BCH_ECC), .BCH_SLOT(BCH_SLOT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_valid(in_valid),
    .bch(q_bch), .chunks(q_chunks), .dlen(q_dlen), .slen(q_slen),
    .tail_en(q_tail), .tdlen(q_tdlen), .tslen(q_tslen), .telen(q_telen),
    .kind(kind), .idle(idle), .in_ready(in_ready), .pad_wr(pad_wr),
    .beat(beat), .done(done)
  );

  nrd_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .kind(kind), .beat(beat),
    .spare_base(spare_base), .ecc_base(ecc_base), .wr_addr(wr_addr)
  );

  assign wr_en   = beat;
  assign wr_data = pad_wr ? PAD_BYTE : in_data;

  // R6: any write not fed by the stream is a 0xFF pad byte
  assert_pad_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(in_valid && in_ready)) |-> (wr_data == PAD_BYTE));

  // R8: nothing is written while idle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!wr_en && !in_ready));
endmodule

// File: tb/tb_nand_page_reorder.sv
module tb_nand_page_reorder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_bch = 1'b0;
  logic [3:0]  cfg_chunks = '0;
  logic [11:0] cfg_data_len = '0, cfg_spare_len = '0;
  logic        cfg_tail_en = 1'b0;
  logic [11:0] cfg_tail_data_len = '0, cfg_tail_spare_len = '0;
  logic [4:0]  cfg_tail_ecc_len = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, wr_en, done;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  always #5 clk = ~clk;

  nand_page_reorder dut (.*);

  int checks = 0, fails = 0;
  bit [7:0] stream[$];
  int       exp_addr[$];
  bit [7:0] exp_data[$];
  bit       exp_pad[$];
  string    exp_tag[$];
  int       idx, page_writes, done_cnt = 0;
  bit       took, expect_done = 0, done_prev = 0;
  string    cur_tag = "R8";
  logic [15:0] lfsr = 16'hACE1;
  int       seed = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int a, input string tag);
    bit [7:0] b = 8'((seed * 13 + 5) ^ (seed >> 8));
    seed++;
    stream.push_back(b);
    exp_addr.push_back(a); exp_data.push_back(b);
    exp_pad.push_back(1'b0); exp_tag.push_back(tag);
  endtask

  task automatic pad(input int a, input string tag);
    exp_addr.push_back(a); exp_data.push_back(8'hFF);
    exp_pad.push_back(1'b1); exp_tag.push_back(tag);
  endtask

  // Behavioural layout model: walks the controller order, assigns user addresses
  task automatic build(input int bch, ch, dl, sl, ten, tdl, tsl, tel);
    int dt, st, dp, sp, ep;
    stream.delete();
    if (bch == 0) begin
      dt = ch * 512;
      for (int k = 0; k < dt; k++) put(k, "R3");
      for (int k = 0; k < ch * 6; k++) put(dt + sl + k, "R4");
      for (int k = 0; k < sl; k++) put(dt + k, "R4");
    end else begin
      dt = ch * dl + (ten != 0 ? tdl : 0);
      st = ch * sl + (ten != 0 ? tsl : 0);
      dp = 0; sp = dt; ep = dt + st;
      for (int s = 0; s < ch; s++) begin
        for (int k = 0; k < dl; k++) put(dp++, "R5");
        for (int k = 0; k < sl; k++) put(sp++, "R5");
        for (int k = 0; k < 30; k++) put(ep++, "R5");
        for (int k = 0; k < 2; k++) pad(ep++, "R6");
      end
      if (ten != 0) begin
        for (int k = 0; k < tdl; k++) put(dp++, "R7");
        for (int k = 0; k < tsl; k++) put(sp++, "R7");
        for (int k = 0; k < tel; k++) put(ep++, "R7");
        if (tel > 0) for (int k = tel; k < 32; k++) pad(ep++, "R7");
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      took = in_valid && in_ready;
      if (in_ready && exp_pad.size() > 0 && exp_pad[0])
        chk(0, "R6", "in_ready high during pad", 1, 0);
      if (wr_en) begin
        page_writes++;
        if (exp_addr.size() == 0) chk(0, cur_tag, "unexpected write addr", wr_addr, -1);
        else begin
          chk(wr_addr == exp_addr[0][15:0], exp_tag[0], "write addr", wr_addr, exp_addr[0]);
          chk(wr_data == exp_data[0], exp_tag[0], "write data", wr_data, exp_data[0]);
          void'(exp_addr.pop_front()); void'(exp_data.pop_front());
          void'(exp_pad.pop_front()); void'(exp_tag.pop_front());
        end
      end
      if (done) begin
        chk(expect_done, "R10", "done without accepted start", 1, 0);
        chk(!done_prev, "R9", "done longer than one cycle", 1, 0);
        chk(exp_addr.size() == 0, "R9", "writes left at done", exp_addr.size(), 0);
        done_cnt++;
      end
      done_prev = done;
    end
  end

  task automatic drive();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_page(input int bch, ch, dl, sl, ten, tdl, tsl, tel,
                          input bit gaps, input bit scramble, input string tag);
    int d0, guard, total;
    build(bch, ch, dl, sl, ten, tdl, tsl, tel);
    total = exp_addr.size();
    idx = 0; page_writes = 0; took = 0; expect_done = 1; cur_tag = tag;
    d0 = done_cnt;
    @(posedge clk); #1;
    cfg_bch = bch[0]; cfg_chunks = 4'(ch); cfg_data_len = 12'(dl);
    cfg_spare_len = 12'(sl); cfg_tail_en = ten[0]; cfg_tail_data_len = 12'(tdl);
    cfg_tail_spare_len = 12'(tsl); cfg_tail_ecc_len = 5'(tel);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (scramble) begin
      cfg_chunks = 4'd1; cfg_data_len = 12'd700; cfg_spare_len = 12'd1;
      cfg_tail_en = ~cfg_tail_en; cfg_tail_ecc_len = 5'd3; cfg_bch = ~cfg_bch;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 20000) begin
      if (took) begin idx++; took = 0; end
      drive();
      in_valid = (idx < stream.size()) && (!gaps || lfsr[1:0] != 2'b00);
      in_data  = in_valid ? stream[idx] : 8'h00;
      @(posedge clk); #1;
      guard++;
    end
    if (took) begin idx++; took = 0; end
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(done_cnt == d0 + 1, "R9", "done count for page", done_cnt - d0, 1);
    chk(idx == stream.size(), "R8", "bytes consumed", idx, stream.size());
    chk(page_writes == total, tag, "writes in page", page_writes, total);
    @(negedge clk);
    chk(!in_ready, "R9", "in_ready after done", in_ready, 0);
    expect_done = 0;
  endtask

  task automatic bad_start(input int bch, ch);
    page_writes = 0; cur_tag = "R10";
    @(posedge clk); #1;
    cfg_bch = bch[0]; cfg_chunks = 4'(ch); cfg_data_len = 12'd512;
    start = 1'b1; in_valid = 1'b1; in_data = 8'h55;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(!in_ready, "R10", "in_ready after ignored start", in_ready, 0);
    chk(page_writes == 0, "R10", "writes after ignored start", page_writes, 0);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet under reset
    chk(!wr_en && !in_ready && !done, "R1", "outputs in reset", {wr_en, in_ready, done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_en && !in_ready && !done, "R1", "outputs after reset", {wr_en, in_ready, done}, 0);

    run_page(0, 1, 0, 10, 0, 0, 0, 0, 1'b1, 1'b0, "R3");
    run_page(0, 4, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "R11");
    run_page(0, 2, 0, 24, 0, 0, 0, 0, 1'b1, 1'b0, "R4");
    run_page(1, 2, 512, 8, 0, 0, 0, 0, 1'b1, 1'b0, "R5");
    run_page(1, 3, 520, 4, 1, 100, 3, 20, 1'b1, 1'b0, "R7");
    run_page(1, 1, 512, 0, 1, 40, 2, 0, 1'b0, 1'b0, "R7");
    run_page(1, 2, 600, 5, 1, 64, 0, 30, 1'b1, 1'b1, "R2");
    bad_start(0, 3);
    bad_start(1, 0);
    run_page(0, 2, 0, 6, 0, 0, 0, 0, 1'b0, 1'b0, "R3");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule